// File: doc/BRIEF.md
# PC Card Socket Status-Change Controller

This block holds the status and interrupt logic for one socket of a 16-bit PC card host bridge. It brings the socket's sense pins (two card-detect pins, two battery-voltage-detect pins, ready, write-protect, two voltage-select pins, the card status-change pin and the card interrupt request) into the core clock domain through a synchronizer. It decodes them into a status byte and latches every change of interest into sticky change flags. A single registered interrupt line goes to the processor whenever an enabled flag is set.

Software sees five byte-wide registers on a simple register bus with a combinational read path:
- 0x0: decoded pin status, read-only.
- 0x2: general socket control. It drives the card reset, the IO/memory card type, the output drive enable, the 16 MB mapping mode and two upper window address bits.
- 0x4: the change flags.
- 0x6: the change interrupt enables.
- 0x8: a free socket control byte that is routed out to the power switch logic.

A change flag is cleared by writing the register back with that bit at zero.

Top module: `pcsock_status_ctl`

## Requirements
- R1: The card counts as present only when both card-detect pins (cardDetN) are low. Status bit 0 is then 1. With any other card-detect code the whole status byte (offset 0x0) reads 0x00.
- R2: With a card present, status bits [2:1] give the battery state: 0 (good) for batDet=2'b11, 1 (warning) for batDet=2'b01, and 2 (dead) for any other code.
- R3: With a card present, status bits [6:5] give the supply class, where voltSel[0] is the first and voltSel[1] the second voltage-select pin:
  - 3 (unsupported low-voltage card) when only voltSel[0] is high.
  - 1 (3.3 V) when neither or only voltSel[1] is high.
  - 2 (5 V) when both are high.
- R4: With a card present, status bit 3 is ready, bit 4 is write-protect and bit 7 is the level of the card interrupt request.
- R5: Change flags at offset 0x4 each set as follows:
  - bit 0: any change of either card-detect pin.
  - bit 1: any change of ready.
  - bit 2: any change in whether the battery code means warning.
  - bit 3: any change in whether the battery code means dead.
  - bit 4: any change of statusChg.
  - bit 5: a rising edge of cardIreq.
- R6: A write to offset 0x4 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. Bits 7:6 read 0.
- R7: When a flag's set event and a write-back clear of that flag fall in the same cycle, the flag ends up set.
- R8: The interrupt enables at offset 0x6 are laid out as follows:
  - bits 0..4 enable flags 0..4 one to one.
  - bits [6:5] form the card interrupt field: code 2'b01 selects level mode and enables flag 5, every other code disables it.
  - irqOut is the OR over all flags of flag AND enable.
- R9: irqOut is registered. It changes one clock after the flag or enable that causes it, and a pin edge reaches its flag two clocks after the synchronizer's first stage captures it.
- R10: The general control register at 0x2 stores bits [5:0] and reads bits 7:6 as 0. cardReset, ioCardMode, cardDrvEn, map16Mode and winHiAddr[1:0] follow bits 0, 1, 2, 3 and [5:4]. The byte at 0x8 stores all 8 bits and drives sockCtl.
- R11: Writes to offset 0x0, to odd offsets and to unmapped offsets change no register. Reads of odd or unmapped offsets return 0x00.
- R12: After reset every register reads 0x00 and irqOut is low. Pin levels present at reset, or settling through the synchronizer after it, set no flag.
- R13: Bit 7 of the enable register is stored and read back but gates nothing. Writing 0x80 after 0xBF turns every interrupt source off and keeps bit 7 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 4 | Register byte offset |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr, combinational |
| cardDetN | input | 2 | Card-detect pins, low when seated |
| batDet | input | 2 | Battery-voltage-detect pins |
| cardReady | input | 1 | Card ready pin |
| writeProt | input | 1 | Card write-protect pin |
| voltSel | input | 2 | Voltage-select pins, bit 0 first pin |
| statusChg | input | 1 | Card status-change pin |
| cardIreq | input | 1 | Card interrupt request, high active |
| irqOut | output | 1 | Registered interrupt to the processor |
| cardReset | output | 1 | Card reset drive |
| ioCardMode | output | 1 | 1 for IO card, 0 for memory card |
| cardDrvEn | output | 1 | Output drive enable toward the card |
| map16Mode | output | 1 | 16 MB mapping mode select |
| winHiAddr | output | 2 | Upper address bits of the common window |
| sockCtl | output | 8 | Socket control byte to power logic |

## Verification
A wrong flag state shows at offset 0x4 on the next read. Through irqOut it shows one clock later, or never if the flag's enable is off, so every interrupt check is paired with a read of the flags. A broken edge detector or arming sequence shows as a flag that is set with no pin change, or one that never sets. Such faults appear within three clocks of the pin change, and the directed latency test samples that exact window. A wrong priority between set and write-back clear appears only when both land in the same cycle, so that case is driven cycle-exactly.

// File: rtl/pcsock_pkg.sv
package pcsock_pkg;

  localparam int DATA_W    = 8;
  localparam int GCTL_W    = 6;
  localparam int NUM_FLAGS = 6;

  // Register byte offsets
  localparam int OFS_STAT = 'h0;
  localparam int OFS_GCTL = 'h2;
  localparam int OFS_CHG  = 'h4;
  localparam int OFS_IEN  = 'h6;
  localparam int OFS_SCTL = 'h8;

  // Change flag positions (shared with the enable register)
  localparam int F_CD    = 0;
  localparam int F_RDY   = 1;
  localparam int F_BWARN = 2;
  localparam int F_BDEAD = 3;
  localparam int F_STS   = 4;
  localparam int F_IREQ  = 5;

  // Card interrupt enable field
  localparam int          IEN_IRQ_LSB = 5;
  localparam logic [1:0]  IREQ_LEVEL  = 2'b01;

  // Watched pin vector given to the control path
  localparam int W_CD    = 0;
  localparam int W_BVD   = 2;
  localparam int W_RDY   = 4;
  localparam int W_STS   = 5;
  localparam int W_IRQ   = 6;
  localparam int WATCH_W = 7;

  // Battery and supply decode codes
  localparam logic [1:0] BAT_GOOD = 2'd0;
  localparam logic [1:0] BAT_WARN = 2'd1;
  localparam logic [1:0] BAT_DEAD = 2'd2;
  localparam logic [1:0] VC_3V3   = 2'd1;
  localparam logic [1:0] VC_5V    = 2'd2;
  localparam logic [1:0] VC_UNSUP = 2'd3;

  typedef enum logic [2:0] {
    RD_NONE, RD_STAT, RD_GCTL, RD_CHG, RD_IEN, RD_SCTL
  } rdSel_e;

  typedef struct packed {
    logic                 wrGctl;
    logic                 wrChg;
    logic                 wrIen;
    logic                 wrSctl;
    logic [NUM_FLAGS-1:0] evt;
    rdSel_e               rdSel;
  } ctlStrobes_t;

  function automatic logic [1:0] batteryCode(input logic [1:0] bvd);
    case (bvd)
      2'b11:   return BAT_GOOD;
      2'b01:   return BAT_WARN;
      default: return BAT_DEAD;
    endcase
  endfunction

  // vs[0] is the first select pin, vs[1] the second
  function automatic logic [1:0] voltClass(input logic [1:0] vs);
    case (vs)
      2'b01:   return VC_UNSUP;
      2'b11:   return VC_5V;
      default: return VC_3V3;
    endcase
  endfunction

endpackage

// File: rtl/pcsock_sync.sv
module pcsock_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/pcsock_ctrl.sv
module pcsock_ctrl
  import pcsock_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [WATCH_W-1:0] watchNow,
  output ctlStrobes_t        strb
);

  // The arming chain fills one stage per clock; edges count only once the
  // synchronizer and the previous-value register both hold real pin samples.
  localparam int PRIME_W = SYNC_STAGES + 1;

  logic [PRIME_W-1:0] primeSr;
  logic [WATCH_W-1:0] watchPrev;
  logic               armed;
  logic [1:0]         batNow, batPrev;
  logic [NUM_FLAGS-1:0] evtRaw;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primeSr   <= '0;
      watchPrev <= '0;
    end else begin
      primeSr   <= {primeSr[PRIME_W-2:0], 1'b1};
      watchPrev <= watchNow;
    end
  end

  assign armed   = primeSr[PRIME_W-1];
  assign batNow  = batteryCode(watchNow[W_BVD +: 2]);
  assign batPrev = batteryCode(watchPrev[W_BVD +: 2]);

  always_comb begin
    evtRaw          = '0;
    evtRaw[F_CD]    = watchNow[W_CD +: 2] != watchPrev[W_CD +: 2];
    evtRaw[F_RDY]   = watchNow[W_RDY] ^ watchPrev[W_RDY];
    evtRaw[F_BWARN] = (batNow == BAT_WARN) != (batPrev == BAT_WARN);
    evtRaw[F_BDEAD] = (batNow == BAT_DEAD) != (batPrev == BAT_DEAD);
    evtRaw[F_STS]   = watchNow[W_STS] ^ watchPrev[W_STS];
    evtRaw[F_IREQ]  = watchNow[W_IRQ] & ~watchPrev[W_IRQ];
  end

  always_comb begin
    strb        = '0;
    strb.evt    = armed ? evtRaw : '0;
    strb.rdSel  = RD_NONE;
    case (regAddr)
      ADDR_W'(OFS_STAT): strb.rdSel = RD_STAT;
      ADDR_W'(OFS_GCTL): begin strb.rdSel = RD_GCTL; strb.wrGctl = regWrEn; end
      ADDR_W'(OFS_CHG):  begin strb.rdSel = RD_CHG;  strb.wrChg  = regWrEn; end
      ADDR_W'(OFS_IEN):  begin strb.rdSel = RD_IEN;  strb.wrIen  = regWrEn; end
      ADDR_W'(OFS_SCTL): begin strb.rdSel = RD_SCTL; strb.wrSctl = regWrEn; end
      default:           strb.rdSel = RD_NONE;
    endcase
  end

endmodule

// File: rtl/pcsock_datapath.sv
module pcsock_datapath
  import pcsock_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobes_t          strb,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [1:0]           cdN,
  input  logic [1:0]           bvd,
  input  logic                 rdy,
  input  logic                 wp,
  input  logic [1:0]           vs,
  input  logic                 ireq,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irqOut,
  output logic [GCTL_W-1:0]    gctlReg,
  output logic [DATA_W-1:0]    sctlReg,
  output logic [NUM_FLAGS-1:0] chgFlags,
  output logic [DATA_W-1:0]    ienReg,
  output logic [DATA_W-1:0]    statusByte
);

  logic [NUM_FLAGS-1:0] srcEn;
  logic                 irqNext;

  // Decoded status; all fields forced to zero without a seated card
  always_comb begin
    statusByte = '0;
    if (cdN == 2'b00) begin
      statusByte[0]   = 1'b1;
      statusByte[2:1] = batteryCode(bvd);
      statusByte[3]   = rdy;
      statusByte[4]   = wp;
      statusByte[6:5] = voltClass(vs);
      statusByte[7]   = ireq;
    end
  end

  // Sticky flags: hardware set outranks write-back clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chgFlags <= '0;
    end else begin
      for (int i = 0; i < NUM_FLAGS; i++) begin
        if (strb.evt[i]) begin
          chgFlags[i] <= 1'b1;
        end else if (strb.wrChg && !wrData[i]) begin
          chgFlags[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gctlReg <= '0;
      ienReg  <= '0;
      sctlReg <= '0;
    end else begin
      if (strb.wrGctl) gctlReg <= wrData[GCTL_W-1:0];
      if (strb.wrIen)  ienReg  <= wrData;
      if (strb.wrSctl) sctlReg <= wrData;
    end
  end

  // Per-source enables: single bits for the status sources, a coded field
  // for the card interrupt request
  genvar g;
  generate
    for (g = 0; g < NUM_FLAGS; g++) begin : g_src
      if (g == F_IREQ) begin : g_field
        assign srcEn[g] = ienReg[IEN_IRQ_LSB +: 2] == IREQ_LEVEL;
      end else begin : g_bit
        assign srcEn[g] = ienReg[g];
      end
    end
  endgenerate

  assign irqNext = |(chgFlags & srcEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= irqNext;
  end

  always_comb begin
    case (strb.rdSel)
      RD_STAT: rdData = statusByte;
      RD_GCTL: rdData = DATA_W'(gctlReg);
      RD_CHG:  rdData = DATA_W'(chgFlags);
      RD_IEN:  rdData = ienReg;
      RD_SCTL: rdData = sctlReg;
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/pcsock_status_ctl.sv
module pcsock_status_ctl
  import pcsock_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic [1:0]        cardDetN,
  input  logic [1:0]        batDet,
  input  logic              cardReady,
  input  logic              writeProt,
  input  logic [1:0]        voltSel,
  input  logic              statusChg,
  input  logic              cardIreq,
  output logic              irqOut,
  output logic              cardReset,
  output logic              ioCardMode,
  output logic              cardDrvEn,
  output logic              map16Mode,
  output logic [1:0]        winHiAddr,
  output logic [7:0]        sockCtl
);

  localparam int PIN_W = 11;

  logic [PIN_W-1:0]     pinRaw, pinSync;
  logic [WATCH_W-1:0]   watchNow;
  ctlStrobes_t          strb;
  logic [GCTL_W-1:0]    gctlReg;
  logic [NUM_FLAGS-1:0] chgFlags;
  logic [DATA_W-1:0]    ienReg;
  logic [DATA_W-1:0]    statusByte;

  assign pinRaw = {cardIreq, statusChg, voltSel, writeProt, cardReady, batDet, cardDetN};

  pcsock_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .d(pinRaw), .q(pinSync)
  );

  // sync layout: [1:0] cd, [3:2] bvd, [4] rdy, [5] wp, [7:6] vs, [8] sts, [9] irq
  assign watchNow = {pinSync[9], pinSync[8], pinSync[4], pinSync[3:2], pinSync[1:0]};

  pcsock_ctrl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .watchNow(watchNow), .strb(strb)
  );

  pcsock_datapath uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(regWrData),
    .cdN(pinSync[1:0]), .bvd(pinSync[3:2]), .rdy(pinSync[4]), .wp(pinSync[5]),
    .vs(pinSync[7:6]), .ireq(pinSync[9]),
    .rdData(regRdData), .irqOut(irqOut), .gctlReg(gctlReg), .sctlReg(sockCtl),
    .chgFlags(chgFlags), .ienReg(ienReg), .statusByte(statusByte)
  );

  assign cardReset  = gctlReg[0];
  assign ioCardMode = gctlReg[1];
  assign cardDrvEn  = gctlReg[2];
  assign map16Mode  = gctlReg[3];
  assign winHiAddr  = gctlReg[5:4];

endmodule

// File: rtl/pcsock_status_chk.sv
module pcsock_status_chk
  import pcsock_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    regAddr,
  input logic                 regWrEn,
  input logic [NUM_FLAGS-1:0] clrData,
  input logic                 irqOut,
  input logic [NUM_FLAGS-1:0] chgFlags,
  input logic [DATA_W-1:0]    ienReg,
  input logic [DATA_W-1:0]    statusByte,
  input logic [GCTL_W-1:0]    gctlOut
);

  logic [NUM_FLAGS-1:0] wantMask;
  logic [NUM_FLAGS-1:0] clrAllowed;
  logic                 irqWant;

  always_comb begin
    wantMask         = ienReg[NUM_FLAGS-1:0];
    wantMask[F_IREQ] = (ienReg[6:5] == 2'b01);
  end
  assign irqWant    = |(chgFlags & wantMask);
  assign clrAllowed = (regWrEn && regAddr == ADDR_W'(OFS_CHG)) ? ~clrData : '0;

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == $past(irqWant)); // R8

  AST_CLEAR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(chgFlags) & ~chgFlags & ~$past(clrAllowed)) == '0); // R6

  AST_ABSENT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !statusByte[0] |-> statusByte == '0); // R1

  AST_GCTL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == ADDR_W'(OFS_GCTL)) |=> $stable(gctlOut)); // R10

  AST_IEN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == ADDR_W'(OFS_IEN)) |=> $stable(ienReg)); // R13

endmodule

bind pcsock_status_ctl pcsock_status_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .clrData(regWrData[5:0]), .irqOut(irqOut), .chgFlags(chgFlags),
  .ienReg(ienReg), .statusByte(statusByte),
  .gctlOut({winHiAddr, map16Mode, cardDrvEn, ioCardMode, cardReset})
);

// File: tb/pcsock_status_ctl_test.sv
module pcsock_status_ctl_test;

  localparam int CLK_PERIOD = 10;
  localparam int SEED       = 32'h5eed;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       rstN;
  logic [3:0] regAddr;
  logic       regWrEn;
  logic [7:0] regWrData;
  logic [7:0] regRdData;
  logic       irqOut, cardReset, ioCardMode, cardDrvEn, map16Mode;
  logic [1:0] winHiAddr;
  logic [7:0] sockCtl;

  // Bench pin vector: [1:0] cdN, [3:2] bvd, [4] rdy, [5] wp, [7:6] vs, [8] sts, [9] ireq
  logic [9:0] pv;

  pcsock_status_ctl uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .cardDetN(pv[1:0]), .batDet(pv[3:2]), .cardReady(pv[4]), .writeProt(pv[5]),
    .voltSel(pv[7:6]), .statusChg(pv[8]), .cardIreq(pv[9]),
    .irqOut(irqOut), .cardReset(cardReset), .ioCardMode(ioCardMode),
    .cardDrvEn(cardDrvEn), .map16Mode(map16Mode), .winHiAddr(winHiAddr),
    .sockCtl(sockCtl)
  );

  int         nChk = 0;
  int         nFail = 0;
  bit         finished = 0;
  logic [5:0] mFlags;
  logic [5:0] mGctl;
  logic [7:0] mIen, mSctl;

  function automatic logic [7:0] expStatus(input logic [9:0] p);
    logic [1:0] bat, volt;
    if (p[1:0] != 2'b00) return 8'h00;
    bat  = (p[3:2] == 2'b11) ? 2'd0 : (p[3:2] == 2'b01) ? 2'd1 : 2'd2;
    volt = (p[7:6] == 2'b01) ? 2'd3 : (p[7:6] == 2'b11) ? 2'd2 : 2'd1;
    return {p[9], volt, p[5], p[4], bat, 1'b1};
  endfunction

  function automatic logic isWarn(input logic [1:0] b);
    return b == 2'b01;
  endfunction

  function automatic logic isDead(input logic [1:0] b);
    return b != 2'b11 && b != 2'b01;
  endfunction

  function automatic logic [5:0] expEvt(input logic [9:0] o, input logic [9:0] n);
    logic [5:0] e;
    e[0] = o[1:0] != n[1:0];
    e[1] = o[4] != n[4];
    e[2] = isWarn(o[3:2]) != isWarn(n[3:2]);
    e[3] = isDead(o[3:2]) != isDead(n[3:2]);
    e[4] = o[8] != n[8];
    e[5] = !o[9] && n[9];
    return e;
  endfunction

  function automatic logic expIrq(input logic [5:0] f, input logic [7:0] en);
    return (|(f[4:0] & en[4:0])) || (f[5] && en[6:5] == 2'b01);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    case (a)
      4'h2: mGctl = d[5:0];
      4'h4: mFlags = mFlags & d[5:0];
      4'h6: mIen = d;
      4'h8: mSctl = d;
      default: ;
    endcase
  endtask

  task automatic setPins(input logic [9:0] n);
    @(negedge clk);
    mFlags = mFlags | expEvt(pv, n);
    pv = n;
    repeat (5) @(negedge clk);
  endtask

  task automatic checkAll(input string req);
    logic [7:0] d;
    rd(4'h0, d); chk(req, "status", d, expStatus(pv));
    rd(4'h2, d); chk(req, "gctl", d, {2'b00, mGctl});
    rd(4'h4, d); chk(req, "flags", d, {2'b00, mFlags});
    rd(4'h6, d); chk(req, "ienable", d, mIen);
    rd(4'h8, d); chk(req, "sctl", d, mSctl);
    chk(req, "sockCtl pins", sockCtl, mSctl);
    chk(req, "gctl pins", {2'b00, winHiAddr, map16Mode, cardDrvEn, ioCardMode, cardReset},
        {2'b00, mGctl});
    chk(req, "irqOut", {7'b0, irqOut}, {7'b0, expIrq(mFlags, mIen)});
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0] d;
    logic [9:0] old;
    int unsigned sd;
    sd = $urandom(SEED);
    rstN = 1'b0; regAddr = '0; regWrEn = 1'b0; regWrData = '0;
    pv = 10'b00_00_0_0_11_11;   // empty socket, battery code 11
    mFlags = '0; mGctl = '0; mIen = '0; mSctl = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (6) @(negedge clk);

    // R12: reset values, pins present at reset set no flag
    checkAll("R12");

    // R11: writes to status, odd and unmapped offsets are ignored
    wr(4'h0, 8'hFF); wr(4'hA, 8'hFF); wr(4'h3, 8'hFF); wr(4'hF, 8'hFF);
    checkAll("R11");
    rd(4'hA, d); chk("R11", "unmapped read", d, 8'h00);
    rd(4'h5, d); chk("R11", "odd read", d, 8'h00);

    // R1: one card-detect pin low is not a card
    setPins(10'b0_0_11_1_1_11_10); checkAll("R1");
    setPins(10'b0_0_11_1_1_11_01); checkAll("R1");
    setPins(10'b0_0_11_0_1_11_00); checkAll("R1");

    // R2: battery decode
    setPins(10'b0_0_11_0_1_01_00); checkAll("R2");
    setPins(10'b0_0_11_0_1_10_00); checkAll("R2");
    setPins(10'b0_0_11_0_1_00_00); checkAll("R2");
    setPins(10'b0_0_11_0_1_11_00); checkAll("R2");

    // R3: voltage-select decode
    setPins(10'b0_0_00_0_1_11_00); checkAll("R3");
    setPins(10'b0_0_01_0_1_11_00); checkAll("R3");
    setPins(10'b0_0_10_0_1_11_00); checkAll("R3");
    setPins(10'b0_0_11_0_1_11_00); checkAll("R3");

    // R4: ready, write-protect, interrupt level
    setPins(10'b1_0_11_1_0_11_00); checkAll("R4");
    setPins(10'b0_0_11_1_1_11_00); checkAll("R4");

    // R6: write ones keeps, zero clears
    wr(4'h4, 8'hFF); checkAll("R6");
    wr(4'h4, 8'hFE); checkAll("R6");
    wr(4'h4, 8'h00); checkAll("R6");

    // R5: each source on its own
    setPins(pv ^ 10'h001); checkAll("R5"); wr(4'h4, 8'h00);
    setPins(pv ^ 10'h001); checkAll("R5"); wr(4'h4, 8'h00);
    setPins(pv ^ 10'h010); checkAll("R5"); wr(4'h4, 8'h00);
    setPins({pv[9:4], 2'b01, pv[1:0]}); checkAll("R5"); wr(4'h4, 8'h00);
    setPins({pv[9:4], 2'b00, pv[1:0]}); checkAll("R5"); wr(4'h4, 8'h00);
    setPins(pv ^ 10'h100); checkAll("R5"); wr(4'h4, 8'h00);
    setPins(pv | 10'h200); checkAll("R5"); wr(4'h4, 8'h00);
    setPins(pv & ~10'h200); checkAll("R5");

    // R7: set and clear of the ready flag in the same cycle
    wr(4'h4, 8'h00);
    setPins(pv ^ 10'h010);
    @(negedge clk); old = pv; pv = pv ^ 10'h010;
    @(negedge clk);
    @(negedge clk); regAddr = 4'h4; regWrData = 8'hFD; regWrEn = 1'b1;
    @(negedge clk); regWrEn = 1'b0;
    mFlags = (mFlags & 6'h3D) | expEvt(old, pv);
    repeat (3) @(negedge clk);
    checkAll("R7");
    rd(4'h4, d); chk("R7", "ready flag kept", {7'b0, d[1]}, 8'h01);

    // R9: latency from pin edge to flag and to irqOut
    wr(4'h4, 8'h00); wr(4'h6, 8'h01);
    @(negedge clk); mFlags = mFlags | expEvt(pv, pv ^ 10'h001); pv = pv ^ 10'h001;
    regAddr = 4'h4;
    @(negedge clk);
    @(negedge clk); #1 chk("R9", "flag before", {7'b0, regRdData[0]}, 8'h00);
    @(negedge clk); #1 chk("R9", "flag set", {7'b0, regRdData[0]}, 8'h01);
    chk("R9", "irq one cycle late", {7'b0, irqOut}, 8'h00);
    @(negedge clk); #1 chk("R9", "irq up", {7'b0, irqOut}, 8'h01);
    checkAll("R9");

    // R8: card interrupt field codes
    wr(4'h6, 8'h00); wr(4'h4, 8'h00);
    setPins(pv & ~10'h200); setPins(pv | 10'h200);
    wr(4'h6, 8'h20); checkAll("R8");
    wr(4'h6, 8'h40); checkAll("R8");
    wr(4'h6, 8'h60); checkAll("R8");
    wr(4'h6, 8'h1F); checkAll("R8");

    // R13: all on, then all off keeping bit 7
    wr(4'h6, 8'hBF); checkAll("R13");
    wr(4'h6, 8'h80); checkAll("R13");
    rd(4'h6, d); chk("R13", "bit7 kept", d, 8'h80);

    // R10: control registers and their outputs
    wr(4'h2, 8'hFF); checkAll("R10");
    wr(4'h2, 8'h95); wr(4'h8, 8'hA5); checkAll("R10");

    // Random mix against the model (R5, R6, R8)
    for (int it = 0; it < 400; it++) begin
      case ($urandom % 6)
        0, 1:    setPins(pv ^ 10'($urandom));
        2:       wr(4'h4, 8'($urandom));
        3:       wr(4'h6, 8'($urandom));
        4:       wr(4'h2, 8'($urandom));
        default: wr(4'h8, 8'($urandom));
      endcase
      repeat (2) @(negedge clk);
      checkAll("R5/R6/R8 random");
    end

    finishRun();
  end

endmodule